// File: doc/BRIEF.md
# Once-per-second Time Advance Sequencer

This block keeps a seconds, minutes and hours counter and advances it once per second from a slow reference time base. The time base reaches the block as a one-clock strobe, `tick_i`, at the reference rate, which is 32.768 kHz by default. A free-running tick counter splits each second into phases. A fixed number of ticks before the advance, the block raises a busy flag, `uip_o`. Software that sees the flag knows the time bytes are about to change and waits before reading them. The counters advance on the last tick of the second. The flag then stays high for a fixed number of further ticks, and when it drops the block emits a one-clock `done_o` pulse.

A freeze input, `set_i`, stops update cycles. While it is high, software loads new values through a small write port without racing the advance. Two mode inputs select the counter format:

- Binary or two-digit BCD counting.
- 24-hour format, or 12-hour format with a PM flag in bit 7 of the hours byte.

Top module: `clk_update_seq`

## Requirements
- R1: Synchronous active-high reset clears all three time bytes to 0x00 and drives `uip_o` and `done_o` low.
- R2: With `set_i` low, `uip_o` rises on a tick and the time bytes advance exactly LEAD_TICKS ticks later, counting the tick that advances them (8 by default).
- R3: After an advance, `uip_o` falls exactly TAIL_TICKS ticks later (65 by default). `done_o` is high for exactly one clock, in the cycle in which `uip_o` is first seen low.
- R4: While `set_i` is high, `uip_o` stays low, no `done_o` pulse occurs and the time bytes change only through the write port.
- R5: When `bin_i` is 1, seconds and minutes count in binary from 0 to 59 (0x3B). From 59 each wraps to 0 and carries into the next field.
- R6: When `bin_i` is 0, each field is two BCD digits. A low digit of 9 wraps to 0 and increments the high digit. Seconds and minutes wrap from 0x59 to 0x00 and carry.
- R7: When `h24_i` is 1, hours wrap from 23 to 0 (0x17 in binary, 0x23 in BCD) on a carry out of the minutes.
- R8: When `h24_i` is 0, hour bits 6:0 run 12, 1, 2, … 11, and bit 7 is the PM flag. The flag toggles only on the 11 to 12 step, and the 12 to 1 step keeps it.
- R9: A write with `wr_en_i` high loads `wr_data_i` into one byte on the next clock. The byte is chosen by `wr_sel_i`: 0 selects seconds, 1 selects minutes, 2 selects hours, and 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock strobe at the reference rate |
| set_i | input | 1 | Freeze: suppresses update cycles |
| bin_i | input | 1 | 1 = binary counting, 0 = BCD |
| h24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| wr_en_i | input | 1 | Write strobe for the time bytes |
| wr_sel_i | input | 2 | Byte select: 0 seconds, 1 minutes, 2 hours |
| wr_data_i | input | 8 | Value to load |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hr_o | output | 8 | Hours byte (bit 7 = PM in 12-hour mode) |
| uip_o | output | 1 | Update-in-progress flag |
| done_o | output | 1 | One-clock pulse when an update cycle ends |

## Verification
The assertions assume three things about the inputs:

- Time bytes hold values that are legal for the selected format.
- The mode inputs change only while `set_i` is high.
- Writes happen only while `set_i` is high, so no load lands in the same cycle as an advance.

The stimulus follows all three. It raises the freeze bit, writes the bytes and selects the mode, then drops the freeze bit and waits for the next `done_o` pulse. The stimulus also shortens the second to 128 ticks and toggles `tick_i` every other clock, so that the lead and tail windows can be counted tick by tick.

// File: rtl/clk_update_pkg.sv
package clk_update_pkg;

    typedef struct packed {
        logic [7:0] hr;
        logic [7:0] mn;
        logic [7:0] sc;
    } tod_t;

    typedef struct packed {
        logic       carry;
        logic [7:0] val;
    } step_t;

    // advance a 0..59 field; carry set on the wrap
    function automatic step_t step_sixty(input logic [7:0] v, input logic bin);
        step_t r;
        r.carry = 1'b0;
        r.val   = v + 8'd1;
        if (bin) begin
            if (v >= 8'd59) begin
                r.carry = 1'b1;
                r.val   = 8'd0;
            end
        end else if (v[3:0] >= 4'd9) begin
            if (v[7:4] >= 4'd5) begin
                r.carry = 1'b1;
                r.val   = 8'h00;
            end else begin
                r.val = {v[7:4] + 4'd1, 4'h0};
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] step_hour(input logic [7:0] v, input logic bin,
                                             input logic h24);
        logic [6:0] h;
        logic       pm;
        logic [7:0] r;
        h  = v[6:0];
        pm = v[7];
        if (h24) begin
            if (bin) r = (v >= 8'd23) ? 8'd0 : v + 8'd1;
            else if (v == 8'h23) r = 8'h00;
            else if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
            else r = v + 8'd1;
        end else begin
            if (bin) begin
                if (h >= 7'd12)      r = {pm, 7'd1};
                else if (h == 7'd11) r = {~pm, 7'd12};
                else                 r = {pm, h + 7'd1};
            end else begin
                if (h == 7'h12)      r = {pm, 7'h01};
                else if (h == 7'h11) r = {~pm, 7'h12};
                else if (h[3:0] >= 4'd9) r = {pm, h[6:4] + 3'd1, 4'h0};
                else                 r = {pm, h + 7'd1};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/upd_phase_gen.sv
module upd_phase_gen #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8,
    parameter int TAIL_TICKS    = 65
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic freeze,
    output logic busy,
    output logic advance,
    output logic finished
);
    localparam int PH_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_SEC - 1);
    localparam logic [PH_W-1:0] PH_RISE = PH_W'(TICKS_PER_SEC - LEAD_TICKS - 1);
    localparam logic [PH_W-1:0] PH_FALL = PH_W'(TAIL_TICKS - 1);

    logic [PH_W-1:0] phase;

    initial begin
        if (LEAD_TICKS < 1 || TAIL_TICKS < 1 ||
            LEAD_TICKS + TAIL_TICKS >= TICKS_PER_SEC)
            $error("upd_phase_gen: windows do not fit in one second");
    end

    assign advance = tick && (phase == PH_LAST) && busy && !freeze;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            busy     <= 1'b0;
            finished <= 1'b0;
        end else begin
            finished <= 1'b0;
            if (tick) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
            if (freeze) begin
                busy <= 1'b0;
            end else if (tick && phase == PH_RISE) begin
                busy <= 1'b1;
            end else if (tick && phase == PH_FALL && busy) begin
                busy     <= 1'b0;
                finished <= 1'b1;
            end
        end
    end

    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        finished |=> !finished);                                          // R3
    AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (rst)
        freeze |=> !busy && !finished);                                   // R4
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import clk_update_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  logic       bin,
    input  logic       h24,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output tod_t       tod
);
    tod_t  nxt;
    step_t s_step;
    step_t m_step;

    always_comb begin
        s_step = step_sixty(tod.sc, bin);
        m_step = step_sixty(tod.mn, bin);
        nxt    = tod;
        nxt.sc = s_step.val;
        if (s_step.carry) begin
            nxt.mn = m_step.val;
            if (m_step.carry) nxt.hr = step_hour(tod.hr, bin, h24);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tod <= '0;
        end else begin
            if (advance) tod <= nxt;
            if (wr_en) begin
                case (wr_sel)
                    2'd0:    tod.sc <= wr_data;
                    2'd1:    tod.mn <= wr_data;
                    2'd2:    tod.hr <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    AST_TOD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !advance && !wr_en |=> $stable(tod));                             // R4
    AST_SEC_STEPS: assert property (@(posedge clk) disable iff (rst)
        advance && !wr_en && bin |=> (tod.sc == 8'd0) || (tod.sc == $past(tod.sc) + 8'd1)); // R5
endmodule

// File: rtl/clk_update_seq.sv
module clk_update_seq
    import clk_update_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8,
    parameter int TAIL_TICKS    = 65
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       set_i,
    input  logic       bin_i,
    input  logic       h24_i,
    input  logic       wr_en_i,
    input  logic [1:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hr_o,
    output logic       uip_o,
    output logic       done_o
);
    logic adv;
    tod_t tod;

    upd_phase_gen #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .LEAD_TICKS   (LEAD_TICKS),
        .TAIL_TICKS   (TAIL_TICKS)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_i),
        .freeze  (set_i),
        .busy    (uip_o),
        .advance (adv),
        .finished(done_o)
    );

    tod_counter u_tod (
        .clk    (clk),
        .rst    (rst),
        .advance(adv),
        .bin    (bin_i),
        .h24    (h24_i),
        .wr_en  (wr_en_i),
        .wr_sel (wr_sel_i),
        .wr_data(wr_data_i),
        .tod    (tod)
    );

    assign sec_o = tod.sc;
    assign min_o = tod.mn;
    assign hr_o  = tod.hr;

    AST_ADV_UNDER_UIP: assert property (@(posedge clk) disable iff (rst)
        adv |-> uip_o && !set_i);                                         // R2
    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $fell(uip_o));                                         // R3
endmodule

// File: tb/sim_clk_update_seq.sv
module sim_clk_update_seq;
    localparam int PER  = 128;
    localparam int LEAD = 8;
    localparam int TAIL = 65;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_q = 1'b0;
    logic set_i = 1'b1, bin_i = 1'b1, h24_i = 1'b1;
    logic wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = 2'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic [7:0] sec_o, min_o, hr_o;
    logic uip_o, done_o;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int cycles = 0;
    bit finished = 0;
    logic [23:0] expq[$];
    string tagq[$];

    always #5 clk = ~clk;

    always @(posedge clk) tick_q <= rst ? 1'b0 : ~tick_q;

    clk_update_seq #(.TICKS_PER_SEC(PER), .LEAD_TICKS(LEAD), .TAIL_TICKS(TAIL)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick_q), .set_i(set_i), .bin_i(bin_i),
        .h24_i(h24_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .uip_o(uip_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares the time on every done pulse against the queue
    always @(negedge clk) begin
        if (!rst && done_o) begin
            done_cnt++;
            if (expq.size() > 0) begin
                logic [23:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk({hr_o, min_o, sec_o} == e, t, {hr_o, min_o, sec_o}, e);
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // driver: load a time under freeze, release, queue the expected result
    task automatic run_case(input logic b, input logic h, input logic [23:0] start,
                            input logic [23:0] exp, input string tag);
        int seen;
        @(negedge clk);
        set_i = 1'b1; bin_i = b; h24_i = h;
        wr(2'd0, start[7:0]);
        wr(2'd1, start[15:8]);
        wr(2'd2, start[23:16]);
        chk({hr_o, min_o, sec_o} == start, "R9 write readback", {hr_o, min_o, sec_o}, start);
        expq.push_back(exp);
        tagq.push_back(tag);
        seen = done_cnt;
        set_i = 1'b0;
        wait (done_cnt != seen);
        @(negedge clk);
        set_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk({hr_o, min_o, sec_o} == 24'h0, "R1 reset time", {hr_o, min_o, sec_o}, 0);
        chk(uip_o == 1'b0 && done_o == 1'b0, "R1 reset flags", {uip_o, done_o}, 0);

        // R9: selector value 3 writes nothing
        wr(2'd3, 8'h33);
        chk({hr_o, min_o, sec_o} == 24'h0, "R9 sel3 ignored", {hr_o, min_o, sec_o}, 0);

        // R4: frozen across several seconds
        begin
            int ups = 0, dns = 0;
            wr(2'd0, 8'd5);
            for (int i = 0; i < 3 * 2 * PER; i++) begin
                @(negedge clk);
                if (uip_o) ups++;
                if (done_o) dns++;
            end
            chk(ups == 0, "R4 uip while set", ups, 0);
            chk(dns == 0, "R4 done while set", dns, 0);
            chk(sec_o == 8'd5, "R4 time frozen", sec_o, 5);
        end

        run_case(1, 1, 24'h003B3B, 24'h010000, "R5 binary carry");
        run_case(1, 1, 24'h000A05, 24'h000A06, "R5 binary step");
        run_case(0, 1, 24'h000009, 24'h000010, "R6 bcd digit carry");
        run_case(0, 1, 24'h005959, 24'h010000, "R6 bcd minute carry");
        run_case(0, 1, 24'h091959, 24'h092000, "R6 bcd tens of minutes");
        run_case(1, 1, 24'h173B3B, 24'h000000, "R7 binary 24h wrap");
        run_case(0, 1, 24'h235959, 24'h000000, "R7 bcd 24h wrap");
        run_case(0, 1, 24'h095959, 24'h100000, "R7 bcd hour digit carry");
        run_case(0, 0, 24'h115959, 24'h921200 ^ 24'h001200, "R8 bcd 11am to 12pm");
        run_case(0, 0, 24'h915959, 24'h120000, "R8 bcd 11pm to 12am");
        run_case(0, 0, 24'h925959, 24'h810000, "R8 bcd 12pm to 1pm");
        run_case(1, 0, 24'h8C3B3B, 24'h810000, "R8 binary 12pm to 1pm");
        run_case(1, 0, 24'h093B3B, 24'h0A0000, "R8 binary 9am to 10am");

        // R2 / R3: count ticks around the update with set low
        begin
            int cnt;
            logic [7:0] prev;
            bin_i = 1'b1; h24_i = 1'b1;
            @(negedge clk);
            set_i = 1'b0;
            while (uip_o) @(negedge clk);
            while (!uip_o) @(negedge clk);
            prev = sec_o;
            cnt = 0;
            while (sec_o == prev && cnt < PER) begin
                if (tick_q) cnt++;
                @(negedge clk);
            end
            chk(cnt == LEAD, "R2 lead ticks", cnt, LEAD);
            chk(uip_o == 1'b1, "R2 uip high at advance", uip_o, 1);
            cnt = 0;
            while (uip_o && cnt < PER) begin
                chk(done_o == 1'b0, "R3 no early done", done_o, 0);
                if (tick_q) cnt++;
                @(negedge clk);
            end
            chk(cnt == TAIL, "R3 tail ticks", cnt, TAIL);
            chk(done_o == 1'b1, "R3 done at fall", done_o, 1);
            @(negedge clk);
            chk(done_o == 1'b0, "R3 done one clock", done_o, 0);
            set_i = 1'b1;
        end

        chk(expq.size() == 0, "R3 every update done", expq.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule